// File: doc/BRIEF.md
# Multi-channel ADC scan sequencer

This block steps an external analog-to-digital converter through eight measurement channels and keeps the latest result of each channel. Software sets it up through a small register port. A control register selects the mode, holds the start bit, selects the input range and has five spare storage bits. A second register enables each channel. Eight read-only result registers hold the converted values. When it is started, the sequencer visits the enabled channels in ascending index order and passes over the disabled ones. Before each channel it waits a fixed number of timebase ticks to model the conversion time. It then asks the converter for a sample and stores the answer.

In one-shot mode the block makes a single pass and then clears its own start bit. In continuous mode it repeats the pass once a period, also counted in timebase ticks, has gone by since the previous pass began. It leaves the start bit set. While the low-power input is high the block starts no new conversion and raises a request to leave low power. Scanning resumes once the input falls.

The converter link is a valid/ready-style handshake. `conv_req` acts as valid and `conv_done` acts as ready. While `conv_req` is high, `conv_ch` stays constant, and the request remains up until the converter answers with a `conv_done` that carries the same channel. A slow converter therefore only stretches the scan. No data is lost.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control register reads 0x20 and the enable register reads 0x00. Every result reads 0 and `conv_req` is low.
- R2: Address 0 is the control register and address 1 is the enable register. Control bit 7 selects continuous mode, bit 6 is start, bit 5 is the range select, and bits 4..0 are plain storage. Enable bit i belongs to channel i. Address 8+i reads result i. All other addresses read 0, and reads are combinational.
- R3: In each pass, requests go to the enabled channels only, in ascending index order from 0 to 7.
- R4: Before each channel the block counts CONV_TICKS timebase ticks. It then holds `conv_req` high with a stable `conv_ch` until a `conv_done` arrives whose `conv_done_ch` equals `conv_ch`.
- R5: A result register changes only on a `conv_done` whose channel matches the pending request. A done with a mismatched channel is ignored, and results of disabled channels keep their value.
- R6: In one-shot mode (bit 7 = 0) the start bit reads 0 from the cycle after the last enabled channel's result is accepted.
- R7: In continuous mode the start bit stays 1. A new pass begins when the previous pass has finished and PERIOD_TICKS ticks have elapsed since that pass began.
- R8: With every enable bit 0, a start issues no request. In one-shot mode the start bit clears one cycle after the start is seen.
- R9: While `lp_mode` is high no new request is raised. `lp_exit_req` is high exactly while start is 1 and `lp_mode` is 1.
- R10: When the host clears start, no further request follows. A conversion already requested runs to its done, and its result is stored.
- R11: `conv_range` always equals control bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timebase pulse |
| lp_mode | input | 1 | Device is in low-power mode |
| lp_exit_req | output | 1 | Request to leave low-power mode |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(CH_N)+1 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | RES_W | Register read data |
| conv_req | output | 1 | Conversion request (valid) |
| conv_ch | output | $clog2(CH_N) | Channel of the request |
| conv_range | output | 1 | Range select to the converter |
| conv_done | input | 1 | Converter result strobe (ready) |
| conv_done_ch | input | $clog2(CH_N) | Channel the result belongs to |
| conv_data | input | RES_W | Conversion result |

## Verification
The bench injects a done pulse that carries the wrong channel. A design that ignored the channel tag would write the value into the wrong result register or close the request too early. A sparse enable pattern catches a sequencer that visits disabled channels or does not walk upward. An all-zero enable catches one that hangs with start stuck at 1. The bench also holds low power across a start to catch a design that converts anyway. It clears start while a request is outstanding, which catches a design that drops the in-flight result or keeps scanning. A continuous run catches a design that clears start or fails to rescan on the period.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CONV = 2'd2,
    ST_HOLD = 2'd3
  } scan_st_t;

  localparam int CTL_MODE_BIT  = 7;
  localparam int CTL_START_BIT = 6;
  localparam int CTL_RANGE_BIT = 5;
  localparam logic [7:0] CTL_RST_VAL = 8'h20;
endpackage

// File: rtl/adc_scan_tcnt.sv
module adc_scan_tcnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (clr)          cnt <= '0;
    else if (inc && !hit)  cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == CW'(LIMIT));

  // R4: once the count is reached it stays reached until cleared
  p_sat_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !clr |=> hit);
endmodule

// File: rtl/adc_scan_pick.sv
module adc_scan_pick #(
  parameter int CH_N = 8,
  parameter int CH_W = 3
) (
  input  logic [CH_N-1:0] en,
  input  logic [CH_W:0]   base,
  output logic            found,
  output logic [CH_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = CH_N - 1; i >= 0; i--) begin
      if (en[i] && ((CH_W+1)'(i) >= base)) begin
        found = 1'b1;
        idx   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int CH_N  = 8,
  parameter int RES_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [$clog2(CH_N):0]   addr,
  input  logic [7:0]              wdata,
  output logic [RES_W-1:0]        rdata,
  input  logic                    clr_start,
  input  logic                    res_we,
  input  logic [$clog2(CH_N)-1:0] res_idx,
  input  logic [RES_W-1:0]        res_data,
  output logic [7:0]              ctrl,
  output logic [CH_N-1:0]         en
);
  localparam int CH_W   = $clog2(CH_N);
  localparam int ADDR_W = CH_W + 1;
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(1);

  logic [RES_W-1:0] res [CH_N];
  logic wr_ctl, wr_en;

  assign wr_ctl = we && (addr == A_CTL);
  assign wr_en  = we && (addr == A_EN);

  always_ff @(posedge clk) begin
    if (!rst_n)         ctrl <= CTL_RST_VAL;
    else if (wr_ctl)    ctrl <= wdata;
    else if (clr_start) ctrl[CTL_START_BIT] <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     en <= '0;
    else if (wr_en) en <= wdata[CH_N-1:0];
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_res
    always_ff @(posedge clk) begin
      if (!rst_n)                                 res[g] <= '0;
      else if (res_we && (res_idx == CH_W'(g)))  res[g] <= res_data;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr[ADDR_W-1])     rdata = res[addr[CH_W-1:0]];
    else if (addr == A_CTL) rdata = RES_W'(ctrl);
    else if (addr == A_EN)  rdata = RES_W'(en);
  end

  // R6: a hardware clear of start lands unless the host writes control
  p_start_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_start && !wr_ctl |=> !ctrl[CTL_START_BIT]);
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
  import adc_scan_pkg::*;
#(
  parameter int CH_N         = 8,
  parameter int CONV_TICKS   = 4,
  parameter int PERIOD_TICKS = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    lp_mode,
  input  logic                    start,
  input  logic                    cont,
  input  logic [CH_N-1:0]         en,
  input  logic                    conv_done,
  input  logic [$clog2(CH_N)-1:0] conv_done_ch,
  output logic                    conv_req,
  output logic [$clog2(CH_N)-1:0] conv_ch,
  output logic                    clr_start,
  output logic                    res_we,
  output logic                    lp_exit_req
);
  localparam int CH_W = $clog2(CH_N);

  scan_st_t st, st_n;
  logic [CH_W-1:0] ch, ch_n;
  logic wclr, pclr, whit, phit;
  logic first_found, nxt_found;
  logic [CH_W-1:0] first_idx, nxt_idx;
  logic do_launch, do_finish, done_ok;

  adc_scan_pick #(.CH_N(CH_N), .CH_W(CH_W)) u_first (
    .en(en), .base('0), .found(first_found), .idx(first_idx));

  adc_scan_pick #(.CH_N(CH_N), .CH_W(CH_W)) u_next (
    .en(en), .base({1'b0, ch} + 1'b1), .found(nxt_found), .idx(nxt_idx));

  adc_scan_tcnt #(.LIMIT(CONV_TICKS)) u_wait_cnt (
    .clk(clk), .rst_n(rst_n), .clr(wclr),
    .inc(tick && (st == ST_WAIT) && !lp_mode), .hit(whit));

  adc_scan_tcnt #(.LIMIT(PERIOD_TICKS)) u_period_cnt (
    .clk(clk), .rst_n(rst_n), .clr(pclr),
    .inc(tick && (st != ST_IDLE)), .hit(phit));

  assign done_ok = (st == ST_CONV) && conv_done && (conv_done_ch == ch);

  always_comb begin
    st_n = st; ch_n = ch;
    wclr = 1'b0; pclr = 1'b0; clr_start = 1'b0; res_we = 1'b0;
    do_launch = 1'b0; do_finish = 1'b0;
    case (st)
      ST_IDLE: if (start && !lp_mode) do_launch = 1'b1;
      ST_HOLD: begin
        if (!start)                st_n = ST_IDLE;
        else if (phit && !lp_mode) do_launch = 1'b1;
      end
      ST_WAIT: begin
        if (!start)                st_n = ST_IDLE;
        else if (whit && !lp_mode) st_n = ST_CONV;
      end
      ST_CONV: begin
        if (done_ok) begin
          res_we = 1'b1;
          if (!start) st_n = ST_IDLE;
          else if (nxt_found) begin
            ch_n = nxt_idx; wclr = 1'b1; st_n = ST_WAIT;
          end else do_finish = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (do_launch) begin
      pclr = 1'b1;
      if (first_found) begin
        ch_n = first_idx; wclr = 1'b1; st_n = ST_WAIT;
      end else do_finish = 1'b1;
    end
    if (do_finish) begin
      if (cont) st_n = ST_HOLD;
      else begin
        clr_start = 1'b1; st_n = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      ch <= '0;
    end else begin
      st <= st_n;
      ch <= ch_n;
    end
  end

  assign conv_req    = (st == ST_CONV);
  assign conv_ch     = ch;
  assign lp_exit_req = start && lp_mode;

  // R4: the request and its channel hold until a matching done
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !(conv_done && (conv_done_ch == conv_ch))
      |=> conv_req && $stable(conv_ch));

  // R9: a request is never raised out of low-power mode
  p_req_lp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_req) |-> $past(!lp_mode));

  // R10: with start clear and nothing pending, no request follows
  p_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !conv_req |=> !conv_req);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int CH_N         = 8,
  parameter int RES_W        = 16,
  parameter int CONV_TICKS   = 10,
  parameter int PERIOD_TICKS = 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic                    lp_mode,
  output logic                    lp_exit_req,
  input  logic                    reg_we,
  input  logic [$clog2(CH_N):0]   reg_addr,
  input  logic [7:0]              reg_wdata,
  output logic [RES_W-1:0]        reg_rdata,
  output logic                    conv_req,
  output logic [$clog2(CH_N)-1:0] conv_ch,
  output logic                    conv_range,
  input  logic                    conv_done,
  input  logic [$clog2(CH_N)-1:0] conv_done_ch,
  input  logic [RES_W-1:0]        conv_data
);
  logic [7:0]      ctrl;
  logic [CH_N-1:0] en;
  logic            clr_start, res_we;

  adc_scan_regs #(.CH_N(CH_N), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .clr_start(clr_start),
    .res_we(res_we), .res_idx(conv_ch), .res_data(conv_data),
    .ctrl(ctrl), .en(en));

  adc_scan_fsm #(.CH_N(CH_N), .CONV_TICKS(CONV_TICKS),
                 .PERIOD_TICKS(PERIOD_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lp_mode(lp_mode),
    .start(ctrl[CTL_START_BIT]), .cont(ctrl[CTL_MODE_BIT]), .en(en),
    .conv_done(conv_done), .conv_done_ch(conv_done_ch),
    .conv_req(conv_req), .conv_ch(conv_ch), .clr_start(clr_start),
    .res_we(res_we), .lp_exit_req(lp_exit_req));

  assign conv_range = ctrl[CTL_RANGE_BIT];
endmodule

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CONV_T = 2;
  localparam int PER_T  = 30;
  localparam int MAXCYC = 20000;

  logic clk = 0, rst_n = 0, tick = 0, lp_mode = 0;
  logic reg_we = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic conv_done = 0;
  logic [2:0] conv_done_ch = 0;
  logic [15:0] conv_data = 0;
  logic lp_exit_req, conv_req, conv_range;
  logic [2:0] conv_ch;
  logic [15:0] reg_rdata;

  int checks = 0, errors = 0;
  int rises = 0;
  int order_q[$];
  bit prev_req = 0;
  bit bad_pending = 0;
  int stub_wait = 0, stub_serial = 0;

  // reference model state
  logic [7:0] m_ctrl, m_en;
  logic [15:0] m_res [8];
  int m_st = 0, m_ch = 0, m_w = 0, m_p = 0;

  adc_scan_seq #(.CH_N(8), .RES_W(16), .CONV_TICKS(CONV_T),
                 .PERIOD_TICKS(PER_T)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lp_mode(lp_mode),
    .lp_exit_req(lp_exit_req), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_req(conv_req),
    .conv_ch(conv_ch), .conv_range(conv_range), .conv_done(conv_done),
    .conv_done_ch(conv_done_ch), .conv_data(conv_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int first_en(input int b);
    for (int i = b; i < 8; i++) if (m_en[i]) return i;
    return -1;
  endfunction

  function automatic int model_rd(input int a);
    if (a >= 8) return int'(m_res[a-8]);
    if (a == 0) return int'(m_ctrl);
    if (a == 1) return int'(m_en);
    return 0;
  endfunction

  // reference model, advanced on every rising edge
  always @(posedge clk) begin
    int nst, nch, f;
    bit st_on, cont_on, wclr, pclr, clr, launch, fin;
    if (!rst_n) begin
      m_ctrl = 8'h20; m_en = 0; m_st = 0; m_ch = 0; m_w = 0; m_p = 0;
      for (int i = 0; i < 8; i++) m_res[i] = 0;
    end else begin
      st_on = m_ctrl[6]; cont_on = m_ctrl[7];
      nst = m_st; nch = m_ch; wclr = 0; pclr = 0; clr = 0; launch = 0; fin = 0;
      case (m_st)
        0: if (st_on && !lp_mode) launch = 1;
        3: if (!st_on) nst = 0; else if (m_p == PER_T && !lp_mode) launch = 1;
        1: if (!st_on) nst = 0; else if (m_w == CONV_T && !lp_mode) nst = 2;
        default: if (conv_done && int'(conv_done_ch) == m_ch) begin
          m_res[m_ch] = conv_data;
          if (!st_on) nst = 0;
          else begin
            f = first_en(m_ch + 1);
            if (f >= 0) begin nch = f; wclr = 1; nst = 1; end else fin = 1;
          end
        end
      endcase
      if (launch) begin
        pclr = 1; f = first_en(0);
        if (f >= 0) begin nch = f; wclr = 1; nst = 1; end else fin = 1;
      end
      if (fin) begin
        if (cont_on) nst = 3; else begin clr = 1; nst = 0; end
      end
      if (wclr) m_w = 0;
      else if (tick && m_st == 1 && !lp_mode && m_w < CONV_T) m_w++;
      if (pclr) m_p = 0;
      else if (tick && m_st != 0 && m_p < PER_T) m_p++;
      if (reg_we && reg_addr == 0) m_ctrl = reg_wdata;
      else if (clr) m_ctrl[6] = 1'b0;
      if (reg_we && reg_addr == 1) m_en = reg_wdata;
      m_st = nst; m_ch = nch;
    end
  end

  // compare a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      chk(conv_req == (m_st == 2), "R4 conv_req", conv_req, m_st == 2);
      if (conv_req) chk(int'(conv_ch) == m_ch, "R3 conv_ch", conv_ch, m_ch);
      chk(lp_exit_req == (m_ctrl[6] && lp_mode), "R9 lp_exit_req", lp_exit_req, m_ctrl[6] && lp_mode);
      chk(conv_range == m_ctrl[5], "R11 conv_range", conv_range, m_ctrl[5]);
      chk(int'(reg_rdata) == model_rd(reg_addr), "R2 reg_rdata", reg_rdata, model_rd(reg_addr));
      if (conv_req && !prev_req) begin rises++; order_q.push_back(conv_ch); end
      prev_req = conv_req;
    end
  end

  // timebase and converter stub
  always @(negedge clk) begin
    tick = !tick;
    if (conv_done) conv_done = 0;
    else if (conv_req) begin
      if (stub_wait == 0) stub_wait = 3;
      else begin
        stub_wait--;
        if (stub_wait == 0) begin
          conv_done = 1;
          conv_data = 16'hA000 + 16'(conv_ch) * 16'h100 + 16'(stub_serial);
          conv_done_ch = bad_pending ? (conv_ch ^ 3'd1) : conv_ch;
          bad_pending = 0;
          stub_serial++;
        end
      end
    end else stub_wait = 0;
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_we = 0; reg_addr = 0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); reg_addr = 4'(a);
    @(posedge clk); #(CLK_PERIOD/4); v = int'(reg_rdata);
    @(negedge clk); reg_addr = 0;
  endtask

  task automatic wait_idle(input int maxc);
    for (int i = 0; i < maxc && (m_ctrl[6] || m_st != 0); i++) @(negedge clk);
  endtask

  initial begin
    int v, r0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, v); chk(v == 'h20, "R1 ctrl reset", v, 'h20);
    rd(1, v); chk(v == 0, "R1 enable reset", v, 0);
    for (int i = 0; i < 8; i++) begin
      rd(8 + i, v); chk(v == 0, "R1 result reset", v, 0);
    end
    chk(conv_req == 0, "R1 no request", conv_req, 0);

    // R3 R4 R5 R6 one-shot sparse scan with a mismatched done first
    bad_pending = 1;
    wr(1, 'hA5);
    order_q.delete();
    wr(0, 'h40);
    wait_idle(400);
    chk(order_q.size() == 4, "R3 pass length", order_q.size(), 4);
    if (order_q.size() == 4) begin
      chk(order_q[0] == 0 && order_q[1] == 2 && order_q[2] == 5 && order_q[3] == 7,
          "R3 channel order", order_q[3], 7);
    end
    rd(0, v); chk(v == 'h00, "R6 start cleared", v, 0);
    rd(9, v); chk(v == 0, "R5 mismatched done ignored", v, 0);
    rd(14, v); chk(v == 0, "R5 disabled channel kept", v, 0);
    rd(15, v); chk((v & 'hFF00) == 'hA700, "R5 ch7 stored", v & 'hFF00, 'hA700);

    // R8 all channels disabled
    wr(1, 0);
    r0 = rises;
    wr(0, 'h40);
    repeat (2) @(negedge clk);
    rd(0, v); chk(v == 'h00, "R8 start clears at once", v, 0);
    chk(rises == r0, "R8 no request", rises, r0);

    // R2 R11 spare bits and range
    wr(0, 'h1F);
    rd(0, v); chk(v == 'h1F, "R2 spare bits stored", v, 'h1F);
    chk(conv_range == 0, "R11 range low", conv_range, 0);
    rd(3, v); chk(v == 0, "R2 unmapped address", v, 0);

    // R7 continuous, then R10 stop mid-conversion
    wr(1, 'h03);
    r0 = rises;
    wr(0, 'hE0);
    repeat (220) @(negedge clk);
    rd(0, v); chk(v == 'hE0, "R7 start stays set", v, 'hE0);
    chk(rises - r0 >= 6, "R7 repeated passes", rises - r0, 6);
    for (int i = 0; i < 100 && !conv_req; i++) @(negedge clk);
    wr(0, 'hA0);
    r0 = rises;
    repeat (150) @(negedge clk);
    chk(rises == r0, "R10 no request after stop", rises, r0);
    chk(m_st == 0, "R10 in-flight finished", m_st, 0);
    rd(8, v); chk(v == model_rd(8), "R10 result stored", v, model_rd(8));

    // R9 low power holds off the scan
    wr(1, 'h10);
    lp_mode = 1;
    r0 = rises;
    wr(0, 'h40);
    repeat (30) @(negedge clk);
    chk(rises == r0, "R9 no request in low power", rises, r0);
    chk(lp_exit_req == 1, "R9 exit request", lp_exit_req, 1);
    lp_mode = 0;
    wait_idle(300);
    chk(rises == r0 + 1, "R9 scan after exit", rises, r0 + 1);
    rd(12, v); chk((v & 'hFF00) == 'hA400, "R9 ch4 stored", v & 'hFF00, 'hA400);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAXCYC) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule